// File: doc/BRIEF.md
# Stereo Overload Flag with Retriggerable Hold

This block watches the two channels of a stereo sample stream and raises a single flag when either channel gets close to digital full scale. The limit is about 1.16 dB below the largest code. A sample is looked at only in the clock cycle where the frame strobe is high. Once the flag rises, it stays high for a minimum number of sample frames. Any later frame that again goes over the limit restarts that minimum.

Each channel has a magnitude comparator. The magnitude is formed one bit wider than the sample, so the most negative code cannot wrap. The outputs of the two comparators are ORed into a single trip signal. A two-state controller acts on that trip signal:

- **IDLE**: the flag is low and the frame counter is zero.
- **HOLD**: the flag is high and the counter holds the number of clean frames still needed.

Transitions:

- **TRIP** (IDLE to HOLD): taken on a strobed overload; loads the full hold count.
- **RETRIG** (HOLD to HOLD): taken on a strobed overload; reloads the full count.
- **COUNT** (HOLD to HOLD): taken on a clean strobe while the count is above one; takes one from the count.
- **EXPIRE** (HOLD to IDLE): taken on a clean strobe while the count is one.

Top module: `clip_hold_flag`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released, `ovl_flag` is low and the hold counter is zero. A quiet strobe after reset leaves the flag low.
- R2: A strobed sample whose value is positive raises the flag when the value exceeds 458600. The value 458600 itself does not raise the flag.
- R3: A strobed negative sample raises the flag when its magnitude exceeds 458600. So -458601 trips the flag and -458600 does not.
- R4: The most negative 20-bit code, -524288, always counts as an overload.
- R5: An overload on the right channel alone raises the flag, just as one on the left channel alone does.
- R6: Sample values present while `fs_stb` is low have no effect on the flag or the hold.
- R7: The flag is high in the clock cycle that follows the edge at which an overloading sample was strobed.
- R8: After the last overloading frame, the flag stays high through 511 clean strobes. It drops in the cycle after the 512th clean strobe. This is 512 frames, about 11.6 ms at 44.1 kHz.
- R9: An overload that arrives while the flag is held reloads the full 512-frame hold.
- R10: The hold counts only strobes. Idle clock cycles between strobes do not shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_stb | input | 1 | One-cycle pulse per sample frame; samples are valid in this cycle |
| left_smp | input | 20 | Left channel sample, two's complement |
| right_smp | input | 20 | Right channel sample, two's complement |
| ovl_flag | output | 1 | Overload flag, held for at least 512 frames |

## Verification
The assertions assume that `fs_stb` is a clean single-cycle pulse and that the sample inputs are known (not X) whenever it is high. They assume nothing about the sample values between strobes. The stimulus drives samples and strobe only at falling clock edges and pulses the strobe for exactly one cycle. To test R6, it deliberately parks full-scale values on the samples with the strobe low. Gaps of zero to two idle cycles are left between strobes, so the hold count is seen to follow frames and not clock cycles.

// File: rtl/clip_pkg.sv
package clip_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } clip_state_e;

endpackage

// File: rtl/clip_mag_cmp.sv
module clip_mag_cmp #(
    parameter int SMP_W      = 20,
    parameter int THRESH_MAG = 458600
) (
    input  logic [SMP_W-1:0] smp,
    output logic             over
);
    localparam int EXT_W = SMP_W + 1;

    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] mag;

    always_comb begin
        // one extra bit keeps the negated most-negative code positive
        ext  = {smp[SMP_W-1], smp};
        mag  = smp[SMP_W-1] ? (~ext + 1'b1) : ext;
        over = (mag > EXT_W'(THRESH_MAG));
    end
endmodule

// File: rtl/clip_hold_fsm.sv
module clip_hold_fsm
    import clip_pkg::*;
#(
    parameter int HOLD_FRAMES = 512,
    parameter int CNT_W       = $clog2(HOLD_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_stb,
    input  logic             trip,
    output logic             flag,
    output logic [CNT_W-1:0] hold_cnt
);
    clip_state_e      state, state_nx;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = hold_cnt;
        unique case (state)
            ST_IDLE: begin
                if (fs_stb && trip) begin          // TRIP
                    state_nx = ST_HOLD;
                    cnt_nx   = CNT_W'(HOLD_FRAMES);
                end
            end
            ST_HOLD: begin
                if (fs_stb) begin
                    if (trip) begin                // RETRIG
                        cnt_nx = CNT_W'(HOLD_FRAMES);
                    end else if (hold_cnt == CNT_W'(1)) begin  // EXPIRE
                        state_nx = ST_IDLE;
                        cnt_nx   = '0;
                    end else begin                 // COUNT
                        cnt_nx = hold_cnt - 1'b1;
                    end
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hold_cnt <= '0;
        end else begin
            state    <= state_nx;
            hold_cnt <= cnt_nx;
        end
    end

    always_comb begin
        flag = (state == ST_HOLD);
    end
endmodule

// File: rtl/clip_hold_flag.sv
module clip_hold_flag #(
    parameter int SMP_W       = 20,
    parameter int HOLD_FRAMES = 512,
    parameter int THRESH_MAG  = 458600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_stb,
    input  logic [SMP_W-1:0] left_smp,
    input  logic [SMP_W-1:0] right_smp,
    output logic             ovl_flag
);
    localparam int N_CH  = 2;
    localparam int CNT_W = $clog2(HOLD_FRAMES + 1);

    logic [SMP_W-1:0] chan [N_CH];
    logic [N_CH-1:0]  chan_over;
    logic             trip;
    logic [CNT_W-1:0] hold_cnt;

    assign chan[0] = left_smp;
    assign chan[1] = right_smp;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        clip_mag_cmp #(
            .SMP_W      (SMP_W),
            .THRESH_MAG (THRESH_MAG)
        ) u_cmp (
            .smp  (chan[c]),
            .over (chan_over[c])
        );
    end

    assign trip = |chan_over;

    clip_hold_fsm #(
        .HOLD_FRAMES (HOLD_FRAMES),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs_stb   (fs_stb),
        .trip     (trip),
        .flag     (ovl_flag),
        .hold_cnt (hold_cnt)
    );
endmodule

// File: rtl/clip_hold_flag_chk.sv
module clip_hold_flag_chk #(
    parameter int SMP_W       = 20,
    parameter int HOLD_FRAMES = 512,
    parameter int CNT_W       = $clog2(HOLD_FRAMES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fs_stb,
    input logic [SMP_W-1:0] left_smp,
    input logic [SMP_W-1:0] right_smp,
    input logic             trip,
    input logic             ovl_flag,
    input logic [CNT_W-1:0] hold_cnt
);
    localparam logic [SMP_W-1:0] MOST_NEG = {1'b1, {(SMP_W-1){1'b0}}};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!ovl_flag && hold_cnt == '0));

    // R7
    trip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_stb && trip) |=> ovl_flag);

    // R9
    reload_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_stb && trip) |=> (hold_cnt == CNT_W'(HOLD_FRAMES)));

    // R6
    no_strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_stb && ovl_flag) |=> ovl_flag);

    // R8
    drop_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovl_flag) |-> ($past(fs_stb) && $past(hold_cnt) == CNT_W'(1)));

    // R4
    most_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_stb && (left_smp == MOST_NEG || right_smp == MOST_NEG)) |=> ovl_flag);
endmodule

bind clip_hold_flag clip_hold_flag_chk #(
    .SMP_W       (SMP_W),
    .HOLD_FRAMES (HOLD_FRAMES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_stb    (fs_stb),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .trip      (trip),
    .ovl_flag  (ovl_flag),
    .hold_cnt  (hold_cnt)
);

// File: tb/tb_clip_hold_flag.sv
`timescale 1ns/1ps
module tb_clip_hold_flag;
    localparam int W     = 20;
    localparam int HOLD  = 512;
    localparam int THR   = 458600;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fs_stb = 1'b0;
    logic [W-1:0] left_smp = '0;
    logic [W-1:0] right_smp = '0;
    logic         ovl_flag;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    clip_hold_flag #(
        .SMP_W       (W),
        .HOLD_FRAMES (HOLD),
        .THRESH_MAG  (THR)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_stb    (fs_stb),
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .ovl_flag  (ovl_flag)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: ovl_flag=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fs_stb = 1'b0;
        left_smp = '0;
        right_smp = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one frame; on return the registered flag reflects it
    task automatic strobe(input int l, input int r);
        @(negedge clk);
        left_smp  = W'(l);
        right_smp = W'(r);
        fs_stb    = 1'b1;
        @(negedge clk);
        fs_stb    = 1'b0;
        left_smp  = '0;
        right_smp = '0;
    endtask

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in reset", ovl_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", ovl_flag, 1'b0);
        strobe(1000, -1000);
        check("R1 quiet strobe", ovl_flag, 1'b0);

        // R2/R3/R5: sweep around the threshold, each channel, each sign
        for (int d = -20; d <= 20; d++) begin
            int  m  = THR + d;
            logic ex = (m > THR);
            do_reset(); strobe(m, 0);  check("R2 left pos",  ovl_flag, ex);
            do_reset(); strobe(-m, 0); check("R3 left neg",  ovl_flag, ex);
            do_reset(); strobe(0, m);  check("R5 right pos", ovl_flag, ex);
            do_reset(); strobe(0, -m); check("R5 right neg", ovl_flag, ex);
        end

        // R4: extremes
        do_reset(); strobe(-524288, 0); check("R4 left most negative", ovl_flag, 1'b1);
        do_reset(); strobe(0, -524288); check("R4 right most negative", ovl_flag, 1'b1);
        do_reset(); strobe(524287, 0);  check("R2 positive full scale", ovl_flag, 1'b1);
        do_reset(); strobe(-524287, 0); check("R3 negative full scale", ovl_flag, 1'b1);

        // R6: unstrobed samples ignored
        do_reset();
        @(negedge clk);
        left_smp  = W'(-524288);
        right_smp = W'(524287);
        repeat (4) @(negedge clk);
        check("R6 no strobe", ovl_flag, 1'b0);
        left_smp  = '0;
        right_smp = '0;
        strobe(5, 5);
        check("R6 quiet strobe after", ovl_flag, 1'b0);

        // R7/R8/R10: hold length with idle gaps
        do_reset();
        strobe(500000, 0);
        check("R7 rise next cycle", ovl_flag, 1'b1);
        for (int k = 1; k <= HOLD; k++) begin
            repeat (k % 3) @(negedge clk);
            strobe(100, -100);
            check((k < HOLD) ? "R8 R10 held" : "R8 drop after last", ovl_flag, logic'(k < HOLD));
        end
        repeat (5) @(negedge clk);
        check("R8 stays low", ovl_flag, 1'b0);

        // R9: retrigger reloads
        do_reset();
        strobe(0, -500000);
        for (int k = 1; k <= 300; k++) strobe(0, 0);
        check("R9 held before retrigger", ovl_flag, 1'b1);
        strobe(0, 470000);
        check("R9 retrigger", ovl_flag, 1'b1);
        for (int k = 1; k <= HOLD; k++) begin
            strobe(0, 0);
            if (k == HOLD - 1 || k == HOLD || k == 250)
                check("R9 reloaded hold", ovl_flag, logic'(k < HOLD));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule